// File: doc/BRIEF.md
# Daughterboard GPIO Bank with Reference Clock Output

This block owns the sixteen general-purpose pins that run from the logic to one daughterboard side. Software writes a direction register and an output register. Each write carries a value and a mask, and only the masked bits change, so two agents can share the bank without a read-modify-write. A synchronized copy of the pin levels is always present on the read port.

A separate configuration register can turn pin 0 into a clock source. It holds an enable flag and a 7-bit divisor. When the flag is set, pin 0 is driven as an output with a 50 percent duty clock derived from the system clock, whatever its direction and output bits hold. When the flag is clear, pin 0 goes back to ordinary I/O. The pad drivers are outside this block; it supplies per-pin output value, output enable and the raw input sample.

Top module: `gpio_refclk_bank`

## Requirements
- R1: After reset the direction register, output register, configuration register and readback all hold zero, so every pin is an input (padOe = 0) and padOut = 0.
- R2: A write with wrSel = 0 updates the direction register. Each bit whose wrMask bit is 1 takes the wrValue bit and every other bit is kept. padOe shows the new direction from the cycle after the write edge; a 1 makes the pin an output.
- R3: A write with wrSel = 1 updates the output register with the same masked rule, and padOut shows it from the cycle after the write edge. A mask of zero changes nothing.
- R4: rdData carries padIn through a two-flop synchronizer. A change on padIn appears on rdData after exactly two rising clock edges.
- R5: A write with wrSel = 2 loads the configuration register from wrValue: bit 7 is the enable and bits 6:0 are the divisor. wrMask and wrValue bits 15:8 are ignored.
- R6: While the enable is set, padOe[0] is 1 and padOut[0] follows the divided clock, regardless of direction bit 0 and output bit 0. Pins 15:1 are unaffected.
- R7: With the enable set and a divisor D greater than zero, the divided clock is low right after the configuration write edge. After k further edges it equals bit 0 of k/(D+1), giving a period of 2(D+1) cycles.
- R8: With the enable set and a divisor of zero, pin 0 is driven low continuously.
- R9: With the enable clear, pin 0 takes its direction and value from direction bit 0 and output bit 0 like any other pin.
- R10: A write with wrSel = 3 changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Target: 0 direction, 1 output, 2 configuration, 3 none |
| wrValue | input | 16 | Write data |
| wrMask | input | 16 | Per-bit write enable for direction and output writes |
| rdData | output | 16 | Synchronized pin levels |
| padIn | input | 16 | Raw pin input sample |
| padOut | output | 16 | Pin output values |
| padOe | output | 16 | Pin output enables, 1 = drive |

## Verification
The assertions assume that reset is asserted before the first write and that wrSel, wrValue and wrMask are stable across the edge at which wrEn is sampled. The bench drives all inputs on the falling edge and holds each for a full cycle. The divider assertions also assume that a configuration write can land in any phase of the clock, so the bench reprograms the divisor while the clock is running. The synchronizer check assumes padIn changes only away from the active edge, which the falling-edge drive provides.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANK_W = 16;
  localparam int DIV_W  = 7;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic dirWr;
    logic outWr;
    logic cfgWr;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_bank_pkg::*;
(
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  output gpioStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (wrSel)
        SEL_DIR: strobe.dirWr = 1'b1;
        SEL_OUT: strobe.outWr = 1'b1;
        SEL_CFG: strobe.cfgWr = 1'b1;
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_refclk_gen.sv
module gpio_refclk_gen #(
  parameter int DIV_W = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWr,
  input  logic [DIV_W:0] cfgData,
  output logic         refEn,
  output logic         refClk
);

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] cnt;
  logic             running;

  assign running = refEn && (divisor != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refEn   <= 1'b0;
      divisor <= '0;
    end else if (cfgWr) begin
      refEn   <= cfgData[DIV_W];
      divisor <= cfgData[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      refClk <= 1'b0;
    end else if (cfgWr || !running) begin
      cnt    <= '0;
      refClk <= 1'b0;
    end else if (cnt == divisor) begin
      cnt    <= '0;
      refClk <= ~refClk;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt <= divisor));

  // R7
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !cfgWr && (cnt != divisor)) |=> $stable(refClk));

  // R8
  div_zero_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refEn && (divisor == '0)) |-> !refClk);

  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refEn |-> !refClk);

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_bank_pkg::*;
#(
  parameter int W      = 16,
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  gpioStrobe_t strobe,
  input  logic [W-1:0] wrValue,
  input  logic [W-1:0] wrMask,
  input  logic        refEn,
  input  logic        refClk,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padOe,
  output logic [W-1:0] rdData
);

  logic [W-1:0] dirReg;
  logic [W-1:0] outReg;
  logic [W-1:0] syncStage [SYNC_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
    end else if (strobe.dirWr) begin
      dirReg <= (dirReg & ~wrMask) | (wrValue & wrMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strobe.outWr) begin
      outReg <= (outReg & ~wrMask) | (wrValue & wrMask);
    end
  end

  generate
    for (genvar s = 0; s < SYNC_N; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncStage[s] <= '0;
        end else if (s == 0) begin
          syncStage[s] <= padIn;
        end else begin
          syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign rdData = syncStage[SYNC_N-1];

  generate
    for (genvar i = 0; i < W; i++) begin : gPin
      if (i == 0) begin : gRefPin
        assign padOe[i]  = dirReg[i] | refEn;
        assign padOut[i] = refEn ? refClk : outReg[i];
      end else begin : gPlainPin
        assign padOe[i]  = dirReg[i];
        assign padOut[i] = outReg[i];
      end
    end
  endgenerate

  // R2
  dir_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dirWr |=> (((dirReg ^ $past(dirReg)) & ~$past(wrMask)) == '0));

  // R3
  out_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.outWr |=> (((outReg ^ $past(outReg)) & ~$past(wrMask)) == '0));

  // R10
  idle_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dirWr |=> $stable(dirReg));

  // R6
  upper_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.dirWr && !strobe.outWr) |=> ($stable(padOe[W-1:1]) && $stable(padOut[W-1:1])));

endmodule

// File: rtl/gpio_refclk_bank.sv
module gpio_refclk_bank
  import gpio_bank_pkg::*;
#(
  parameter int W      = BANK_W,
  parameter int DW     = DIV_W,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic [W-1:0] wrValue,
  input  logic [W-1:0] wrMask,
  output logic [W-1:0] rdData,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padOe
);

  gpioStrobe_t strobe;
  logic        refEn;
  logic        refClk;

  gpio_ctrl uCtrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .strobe (strobe)
  );

  gpio_refclk_gen #(.DIV_W(DW)) uRef (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWr   (strobe.cfgWr),
    .cfgData (wrValue[DW:0]),
    .refEn   (refEn),
    .refClk  (refClk)
  );

  gpio_datapath #(.W(W), .SYNC_N(SYNC_N)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrValue (wrValue),
    .wrMask  (wrMask),
    .refEn   (refEn),
    .refClk  (refClk),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .rdData  (rdData)
  );

  // R6
  ref_pin_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    refEn |-> padOe[0]);

endmodule

// File: tb/gpio_refclk_bank_test.sv
module gpio_refclk_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [15:0] wrValue = '0;
  logic [15:0] wrMask = '0;
  logic [15:0] padIn = '0;
  logic [15:0] rdData, padOut, padOe;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_refclk_bank uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrValue(wrValue), .wrMask(wrMask), .rdData(rdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  // {sel, value, mask, expected padOe, expected padOut}
  localparam int NV = 8;
  localparam logic [65:0] VEC [NV] = '{
    {2'd0, 16'hFFFF, 16'h00FF, 16'h00FF, 16'h0000},
    {2'd0, 16'h1234, 16'hF0F0, 16'h103F, 16'h0000},
    {2'd1, 16'hABCD, 16'hFFFF, 16'h103F, 16'hABCD},
    {2'd1, 16'h0000, 16'h00F0, 16'h103F, 16'hAB0D},
    {2'd1, 16'hFFFF, 16'h0000, 16'h103F, 16'hAB0D},
    {2'd3, 16'hFFFF, 16'hFFFF, 16'h103F, 16'hAB0D},
    {2'd0, 16'h0000, 16'h0001, 16'h103E, 16'hAB0D},
    {2'd1, 16'h0000, 16'h0001, 16'h103E, 16'hAB0C}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives at a falling edge, returns at the falling edge after the write edge
  task automatic doWrite(input logic [1:0] sel, input logic [15:0] val, input logic [15:0] msk);
    wrEn = 1'b1; wrSel = sel; wrValue = val; wrMask = msk;
    @(negedge clk);
    wrEn = 1'b0; wrValue = '0; wrMask = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nTests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 oe", padOe, 16'h0000);
    check("R1 out", padOut, 16'h0000);
    check("R1 rd", rdData, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      doWrite(VEC[v][65:64], VEC[v][63:48], VEC[v][47:32]);
      check($sformatf("R2/R3/R10 vec%0d oe", v), padOe, VEC[v][31:16]);
      check($sformatf("R2/R3/R10 vec%0d out", v), padOut, VEC[v][15:0]);
    end

    // R4 two-edge synchronizer latency
    padIn = 16'h5A5A;
    @(negedge clk);
    check("R4 one edge", rdData, 16'h0000);
    @(negedge clk);
    check("R4 two edges", rdData, 16'h5A5A);
    padIn = 16'hC3C3;
    @(negedge clk);
    @(negedge clk);
    check("R4 second pattern", rdData, 16'hC3C3);

    // R5/R6/R7: enable, divisor 3, reserved bits and mask set but ignored
    doWrite(2'd2, 16'hFF83, 16'h0000);
    check("R6 oe forced", padOe, 16'h103F);
    check("R6 upper out", padOut & 16'hFFFE, 16'hAB0C);
    for (int k = 0; k < 16; k++) begin
      check($sformatf("R7 div3 k%0d", k), {15'd0, padOut[0]}, {15'd0, 1'((k / 4) & 1)});
      @(negedge clk);
    end

    // R7 reprogram mid-run to divisor 1
    doWrite(2'd2, 16'h0081, 16'hFFFF);
    for (int k = 0; k < 8; k++) begin
      check($sformatf("R7 div1 k%0d", k), {15'd0, padOut[0]}, {15'd0, 1'((k / 2) & 1)});
      @(negedge clk);
    end

    // R8: divisor zero holds low, even with output bit 0 set
    doWrite(2'd1, 16'h0001, 16'h0001);
    doWrite(2'd2, 16'h0080, 16'h0000);
    for (int k = 0; k < 6; k++) begin
      check("R8 pin low", {15'd0, padOut[0]}, 16'h0000);
      check("R8 pin driven", {15'd0, padOe[0]}, 16'h0001);
      @(negedge clk);
    end

    // R9: disable returns pin 0 to its registers
    doWrite(2'd2, 16'h0000, 16'h0000);
    check("R9 oe", padOe, 16'h103E);
    check("R9 out", padOut, 16'hAB0D);
    doWrite(2'd0, 16'h0001, 16'h0001);
    check("R9 oe follows dir", padOe, 16'h103F);

    // R10: select 3 leaves configuration off
    doWrite(2'd3, 16'h0083, 16'hFFFF);
    repeat (5) @(negedge clk);
    check("R10 pin0 still plain", padOut, 16'hAB0D);

    // R1 again: reset clears a populated bank
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset oe", padOe, 16'h0000);
    check("R1 after reset out", padOut, 16'h0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule